// File: doc/BRIEF.md
# Speculative Load Ordering Queue

This block tracks loads that an out-of-order core issues ahead of program order, so that the core can still appear sequentially consistent to other processors. Each load takes a slot when it dispatches. Slots are handed out in program order from a circular buffer. When the load executes, the core writes the load's address into its slot. From that point on, every invalidating command seen on the coherence bus is compared against the cache line of the load. A match taints the slot.

The core asks to retire the oldest load through the commit port. If that load has executed and is clean, it retires and leaves the queue. If it is tainted, its value may be stale. The block then raises a flush for that slot. The flush empties the slot and every younger slot, and rewinds allocation to the flushed slot, so the core can refetch from that load onward. If the oldest load has not yet executed, the request simply waits.

Each slot is a small state machine with four states:
- FREE: unused.
- PENDING: allocated but not executed.
- DONE: executed and clean.
- TAINTED: executed and hit by a snoop.

The transitions are:
- alloc: FREE to PENDING.
- exec: PENDING to DONE, or PENDING to TAINTED when a matching snoop arrives in the same cycle.
- snoop-hit: DONE to TAINTED.
- retire: DONE to FREE.
- flush: any state to FREE.

The commit decision takes one of four values:
- IDLE: no request, or the queue is empty.
- WAIT: the oldest load is pending.
- RETIRE: the oldest load is done.
- FLUSH: the oldest load is tainted.

DEPTH must be a power of two.

Top module: `spec_load_queue`

## Requirements
- R1: After reset, alloc_ready is 1, alloc_idx is 0, and commit_done and flush_valid are 0.
- R2: Each accepted allocation takes slot alloc_idx. The next slot follows at alloc_idx+1 modulo DEPTH. After DEPTH outstanding loads, alloc_ready is 0. An allocation attempted while alloc_ready is 0 takes no slot.
- R3: A commit request whose oldest load is executed and untainted raises commit_done in the same cycle, with commit_idx equal to that slot. The slot then retires, and the next-oldest slot becomes oldest.
- R4: A commit request raises neither commit_done nor flush_valid when the queue is empty or when the oldest load has not executed.
- R5: A snoop with snp_cmd 2'b01 (bus write) whose address lies in the same line as an executed, uncommitted load taints that load. A commit request on that load then raises flush_valid, with commit_idx equal to the slot.
- R6: A snoop with snp_cmd 2'b10 (bus upgrade) taints matching executed loads in the same way as a bus write.
- R7: A snoop with snp_cmd 2'b00 (bus read) never taints any load. The code 2'b11 taints nothing either.
- R8: A snoop that arrives while a load is allocated but not yet executed does not taint that load.
- R9: Matching ignores the low log2(LINE_BYTES) address bits, which are 6 by default. Addresses in different lines never match.
- R10: If an execute and a matching invalidating snoop reach the same slot in the same cycle, the load is tainted.
- R11: A flush frees the flushed slot and every younger slot. On the next cycle, the queue is empty, alloc_ready is 1, and alloc_idx equals the flushed slot.
- R12: A tainted load that is not yet the oldest causes no flush. Older clean loads still retire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Core dispatches a load this cycle |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_idx | output | IDX_W | Slot given to the load dispatched this cycle |
| exec_valid | input | 1 | A load has computed its address |
| exec_idx | input | IDX_W | Slot of the executing load |
| exec_addr | input | ADDR_W | Byte address of the executing load |
| snp_valid | input | 1 | A bus command is observed |
| snp_cmd | input | 2 | 00 read, 01 write, 10 upgrade, 11 ignored |
| snp_addr | input | ADDR_W | Byte address of the snooped command |
| commit_req | input | 1 | Core wants to retire its oldest load |
| commit_done | output | 1 | Oldest load retires this cycle |
| flush_valid | output | 1 | Oldest load must replay; pipeline flush |
| commit_idx | output | IDX_W | Slot of the oldest load |

## Verification
The main function is exercised with several snoop patterns:
- bus reads on a line that a load has touched;
- writes and upgrades on the same line but at different byte offsets;
- writes to a neighbouring line one byte past the boundary;
- snoops that arrive before the load executes, and one that arrives in the same cycle as the execute.

Together these separate commands that must taint from commands that must not, and line-level matching from exact-address matching. A scoreboard records the expected retire or flush outcome, with its slot, for every commit. The ordering cases use a tainted load behind a clean one and a full wrap of all eight slots. They show whether the oldest-first order and the rewind of the allocation pointer after a flush are kept.

// File: rtl/slq_pkg.sv
package slq_pkg;

    // Lifecycle of one queue slot
    typedef enum logic [1:0] {
        ENT_FREE    = 2'b00,
        ENT_PENDING = 2'b01,
        ENT_DONE    = 2'b10,
        ENT_TAINTED = 2'b11
    } ent_state_e;

    // Observed bus command codes
    typedef enum logic [1:0] {
        SNP_READ    = 2'b00,
        SNP_WRITE   = 2'b01,
        SNP_UPGRADE = 2'b10,
        SNP_RSVD    = 2'b11
    } snp_cmd_e;

    // Outcome of a retirement request on the oldest slot
    typedef enum logic [1:0] {
        RT_IDLE   = 2'b00,
        RT_WAIT   = 2'b01,
        RT_RETIRE = 2'b10,
        RT_FLUSH  = 2'b11
    } rt_dec_e;

endpackage

// File: rtl/slq_entry.sv
module slq_entry
    import slq_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_hit,
    input  logic             exec_hit,
    input  logic [TAG_W-1:0] exec_tag,
    input  logic             snp_inv,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             retire_hit,
    input  logic             flush_all,
    output ent_state_e       state_o
);

    ent_state_e       state_q;
    ent_state_e       state_d;
    logic [TAG_W-1:0] tag_q;
    logic             hit_new;
    logic             hit_old;

    // Snoop against the address arriving now, or against the stored line
    assign hit_new = snp_inv && (snp_tag == exec_tag);
    assign hit_old = snp_inv && (snp_tag == tag_q);

    always_comb begin
        state_d = state_q;
        if (flush_all) begin
            state_d = ENT_FREE;
        end else begin
            unique case (state_q)
                ENT_FREE: begin
                    if (alloc_hit) state_d = ENT_PENDING;
                end
                ENT_PENDING: begin
                    if (exec_hit) state_d = hit_new ? ENT_TAINTED : ENT_DONE;
                end
                ENT_DONE: begin
                    if (retire_hit)   state_d = ENT_FREE;
                    else if (hit_old) state_d = ENT_TAINTED;
                end
                ENT_TAINTED: begin
                    state_d = ENT_TAINTED;
                end
                default: state_d = ENT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENT_PENDING && exec_hit && !flush_all) begin
                tag_q <= exec_tag;
            end
        end
    end

    assign state_o = state_q;

    // R8
    pending_unmarked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_PENDING && !exec_hit) |=> (state_q != ENT_TAINTED));

    // R10
    same_cycle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_PENDING && exec_hit && snp_inv && (snp_tag == exec_tag) && !flush_all)
        |=> (state_q == ENT_TAINTED));

    // R5
    tainted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_TAINTED && !flush_all) |=> (state_q == ENT_TAINTED));

endmodule

// File: rtl/slq_ptr_ctrl.sv
module slq_ptr_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_fire,
    input  logic                     retire,
    input  logic                     flush,
    output logic [$clog2(DEPTH)-1:0] head_idx,
    output logic [$clog2(DEPTH)-1:0] tail_idx,
    output logic                     full,
    output logic                     empty
);

    localparam int IDX_W = $clog2(DEPTH);

    // One extra wrap bit tells full from empty
    logic [IDX_W:0] head_q;
    logic [IDX_W:0] tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            tail_q <= head_q;
        end else begin
            if (retire)     head_q <= head_q + 1'b1;
            if (alloc_fire) tail_q <= tail_q + 1'b1;
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                      (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_fire);

    // R11
    flush_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R3
    retire_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !flush) |=> (head_q == $past(head_q) + 1'b1));

endmodule

// File: rtl/slq_retire_ctl.sv
module slq_retire_ctl
    import slq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit_req,
    input  logic       empty,
    input  ent_state_e head_state,
    output logic       retire,
    output logic       flush
);

    rt_dec_e dec;

    always_comb begin
        dec = RT_IDLE;
        if (commit_req && !empty) begin
            unique case (head_state)
                ENT_DONE:    dec = RT_RETIRE;
                ENT_TAINTED: dec = RT_FLUSH;
                default:     dec = RT_WAIT;
            endcase
        end
    end

    always_comb begin
        retire = (dec == RT_RETIRE);
        flush  = (dec == RT_FLUSH);
    end

    // R4
    head_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty || head_state == ENT_PENDING) |-> !(retire || flush));

endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue
    import slq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_idx,
    input  logic                     exec_valid,
    input  logic [$clog2(DEPTH)-1:0] exec_idx,
    input  logic [ADDR_W-1:0]        exec_addr,
    input  logic                     snp_valid,
    input  logic [1:0]               snp_cmd,
    input  logic [ADDR_W-1:0]        snp_addr,
    input  logic                     commit_req,
    output logic                     commit_done,
    output logic                     flush_valid,
    output logic [$clog2(DEPTH)-1:0] commit_idx
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic             full;
    logic             empty;
    logic             retire_w;
    logic             flush_w;
    logic             alloc_fire;
    logic             snp_inv;
    logic [TAG_W-1:0] exec_tag;
    logic [TAG_W-1:0] snp_tag;
    ent_state_e       ent_st [DEPTH];
    logic [DEPTH-1:0] tainted_vec;
    ent_state_e       head_state;

    assign alloc_ready = !full && !flush_w;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail_idx;
    assign snp_inv     = snp_valid && ((snp_cmd == SNP_WRITE) || (snp_cmd == SNP_UPGRADE));
    assign exec_tag    = exec_addr[ADDR_W-1:OFS_W];
    assign snp_tag     = snp_addr[ADDR_W-1:OFS_W];

    slq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .retire     (retire_w),
        .flush      (flush_w),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .full       (full),
        .empty      (empty)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            slq_entry #(.TAG_W(TAG_W)) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_hit  (alloc_fire && (tail_idx == IDX_W'(g))),
                .exec_hit   (exec_valid && (exec_idx == IDX_W'(g))),
                .exec_tag   (exec_tag),
                .snp_inv    (snp_inv),
                .snp_tag    (snp_tag),
                .retire_hit (retire_w && (head_idx == IDX_W'(g))),
                .flush_all  (flush_w),
                .state_o    (ent_st[g])
            );
            assign tainted_vec[g] = (ent_st[g] == ENT_TAINTED);
        end
    endgenerate

    assign head_state = ent_st[head_idx];

    slq_retire_ctl u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .empty      (empty),
        .head_state (head_state),
        .retire     (retire_w),
        .flush      (flush_w)
    );

    assign commit_done = retire_w;
    assign flush_valid = flush_w;
    assign commit_idx  = head_idx;

    // R7
    read_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_inv |=> ($countones(tainted_vec) <= $past($countones(tainted_vec))));

    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (tainted_vec == '0));

endmodule

// File: tb/spec_load_queue_bench.sv
module spec_load_queue_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 32;
    localparam int IDX_W      = $clog2(DEPTH);

    typedef struct {
        bit    is_flush;
        int    idx;
        string req;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic              alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              exec_valid = 1'b0;
    logic [IDX_W-1:0]  exec_idx = '0;
    logic [ADDR_W-1:0] exec_addr = '0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = 2'b00;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              commit_req = 1'b0;
    logic              commit_done;
    logic              flush_valid;
    logic [IDX_W-1:0]  commit_idx;

    int        n_checks = 0;
    int        n_errors = 0;
    bit        run_over = 0;
    exp_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BYTES(64)) u_spec_load_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .commit_req(commit_req), .commit_done(commit_done),
        .flush_valid(flush_valid), .commit_idx(commit_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!run_over) begin
            run_over = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // One cycle of stimulus, driven just after the falling edge
    task automatic step(input bit a_v, input bit e_v, input int e_i, input int e_a,
                        input bit s_v, input int s_c, input int s_a, input bit c_r);
        @(negedge clk);
        alloc_valid = a_v;
        exec_valid  = e_v;
        exec_idx    = IDX_W'(e_i);
        exec_addr   = ADDR_W'(e_a);
        snp_valid   = s_v;
        snp_cmd     = 2'(s_c);
        snp_addr    = ADDR_W'(s_a);
        commit_req  = c_r;
    endtask

    task automatic idle();        step(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic alloc_one();   step(1, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic exec_one(input int i, input int a); step(0, 1, i, a, 0, 0, 0, 0); endtask
    task automatic snoop(input int c, input int a);    step(0, 0, 0, 0, 1, c, a, 0); endtask
    task automatic commit_one();  step(0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic expect_commit(input bit fl, input int i, input string r);
        exp_item_t it;
        it.is_flush = fl;
        it.idx      = i;
        it.req      = r;
        exp_q.push_back(it);
        commit_one();
    endtask

    task automatic alloc_checked(input int exp_idx, input string r);
        alloc_one();
        #3;
        chk(r, "alloc_ready", int'(alloc_ready), 1);
        chk(r, "alloc_idx", int'(alloc_idx), exp_idx);
    endtask

    // Monitor: pops the scoreboard whenever the design reports a commit outcome
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && (commit_done || flush_valid)) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL R4 unexpected outcome: actual done=%0d flush=%0d expected none",
                             commit_done, flush_valid);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    if (flush_valid != it.is_flush || commit_done == it.is_flush ||
                        int'(commit_idx) != it.idx) begin
                        n_errors++;
                        $display("FAIL %s commit outcome: actual flush=%0d idx=%0d expected flush=%0d idx=%0d",
                                 it.req, flush_valid, commit_idx, it.is_flush, it.idx);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        chk("R1", "alloc_ready", int'(alloc_ready), 1);
        chk("R1", "alloc_idx", int'(alloc_idx), 0);
        chk("R1", "commit_done", int'(commit_done), 0);
        chk("R1", "flush_valid", int'(flush_valid), 0);

        // R4: commit on an empty queue does nothing
        commit_one(); #3;
        chk("R4", "done+flush empty", int'(commit_done) + int'(flush_valid), 0);

        // R2: program-order allocation
        alloc_checked(0, "R2");
        alloc_checked(1, "R2");
        alloc_checked(2, "R2");
        exec_one(0, 'h1000);
        exec_one(1, 'h2000);
        expect_commit(0, 0, "R3");

        // R7: bus read on the same line leaves the load clean
        snoop(0, 'h2010);
        snoop(3, 'h2000);
        expect_commit(0, 1, "R7");

        // R4: oldest load not executed yet
        commit_one(); #3;
        chk("R4", "done+flush pending", int'(commit_done) + int'(flush_valid), 0);

        // R8: invalidation before execute does not taint
        snoop(1, 'h5000);
        exec_one(2, 'h5004);
        expect_commit(0, 2, "R8");

        // R9, R12, R5: line granularity, younger taint waits its turn
        alloc_checked(3, "R2");
        alloc_checked(4, "R2");
        alloc_checked(5, "R2");
        alloc_checked(6, "R2");
        exec_one(3, 'h0100);
        exec_one(4, 'h4000);
        exec_one(5, 'h4040);
        exec_one(6, 'h7000);
        snoop(1, 'h403F);
        expect_commit(0, 3, "R12");
        expect_commit(1, 4, "R5");
        idle(); #3;
        // R11 rewind after flush
        chk("R11", "alloc_ready", int'(alloc_ready), 1);
        chk("R11", "alloc_idx", int'(alloc_idx), 4);
        commit_one(); #3;
        chk("R11", "queue empty after flush", int'(commit_done) + int'(flush_valid), 0);

        // R6: bus upgrade taints
        alloc_checked(4, "R11");
        alloc_checked(5, "R6");
        exec_one(4, 'h8000);
        exec_one(5, 'h9000);
        snoop(2, 'h9020);
        expect_commit(0, 4, "R6");
        expect_commit(1, 5, "R6");
        idle(); #3;
        chk("R11", "alloc_idx", int'(alloc_idx), 5);

        // R10: execute and matching write in the same cycle
        alloc_checked(5, "R10");
        step(0, 1, 5, 'hA004, 1, 1, 'hA030, 0);
        expect_commit(1, 5, "R10");

        // R9: write to a different line during execute does not taint
        alloc_checked(5, "R9");
        step(0, 1, 5, 'hB000, 1, 1, 'hB040, 0);
        expect_commit(0, 5, "R9");

        // R2: fill all slots with wrap, reject the extra one
        for (int k = 0; k < DEPTH; k++) alloc_checked((6 + k) % DEPTH, "R2");
        idle(); #3;
        chk("R2", "alloc_ready full", int'(alloc_ready), 0);
        alloc_one();
        for (int k = 0; k < DEPTH; k++) exec_one((6 + k) % DEPTH, 'h10000 + k * 'h40);
        for (int k = 0; k < DEPTH; k++) expect_commit(0, (6 + k) % DEPTH, "R3");
        idle(); #3;
        chk("R2", "alloc_idx after rejected alloc", int'(alloc_idx), 6);
        chk("R2", "alloc_ready after drain", int'(alloc_ready), 1);

        repeat (2) idle();
        #3;
        while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            n_checks++;
            n_errors++;
            $display("FAIL %s missing outcome: actual=none expected idx=%0d", it.req, it.idx);
        end
        finish_run();
    end

endmodule